// File: doc/BRIEF.md
# Debounced Knob-and-Button Settings Bank

This block keeps five user-adjustable settings for a bouncing-square display: a horizontal speed, a vertical speed, a foreground color, a background color and an object size. Four direction buttons and a pre-decoded rotary knob drive them. The knob supplies a step strobe and a direction level. The block looks at its inputs only on an internal slow tick, which is a few milliseconds apart by default. Contact chatter shorter than the gap between two ticks is therefore never seen.

The north and east buttons each raise one speed by one for each press. Holding a button does not add more steps. The west and south buttons act as modifiers that choose which register a knob step adjusts. The speeds and colors are narrow counters that wrap around. The size is a wider counter that stops at its limits and moves in small or large steps. All five values come out as plain parallel buses.

Top module: `knob_settings_bank`

## Requirements
- R1: After reset, both speeds read 1, the foreground color reads 7, the background color reads 0 and the size reads 16.
- R2: The registers change only on the edge that ends a slow-tick cycle. A tick occurs every TICK_CYCLES clock cycles, counted from reset release.
- R3: A north press raises the vertical speed by one. A press is a low-to-high change between two consecutive tick samples. Holding the button across further ticks adds nothing.
- R4: An east press raises the horizontal speed by one, in the same way as R3.
- R5: With neither west nor south held, a knob step adjusts the foreground color: +1 when knob_up_i is 1 and -1 when it is 0.
- R6: With west held and south released, a knob step adjusts the background color by ±1.
- R7: With south held and west released, a knob step adjusts the size by ±1. The size saturates at 0 and 255.
- R8: With both south and west held, a knob step adjusts the size by ±10. The size saturates at 0 and 255.
- R9: The 3-bit speed and color registers wrap from 7 to 0 going up and from 0 to 7 going down.
- R10: A button pulse that starts and ends between two tick samples has no effect on any register.
- R11: Several knob strobes between two ticks count as one step, and the direction of the last strobe is the one used. That step goes to exactly one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| btn_north_i | input | 1 | Vertical speed button |
| btn_east_i | input | 1 | Horizontal speed button |
| btn_south_i | input | 1 | Modifier that selects the size |
| btn_west_i | input | 1 | Modifier that selects the background, or the large size step |
| knob_step_i | input | 1 | One-cycle knob detent strobe |
| knob_up_i | input | 1 | Knob direction, 1 = increase, valid with the strobe |
| speed_h_o | output | 3 | Horizontal speed |
| speed_v_o | output | 3 | Vertical speed |
| color_fg_o | output | 3 | Foreground color |
| color_bg_o | output | 3 | Background color |
| size_o | output | 8 | Object size |

## Verification
The hardest case to reach from the ports is a button glitch that falls wholly between two tick samples. The tick is internal, so the bench counts clock edges from reset release to find the tick phase. It then places short pulses in the middle of a tick window, and also places two knob strobes of opposite direction in the same window. Reaching the size ceiling at 255 takes a long run of large steps. The bench drives that run through repeated chord-held knob steps.

// File: rtl/knob_settings_pkg.sv
package knob_settings_pkg;
  typedef enum logic [1:0] {
    TGT_FG    = 2'd0,
    TGT_BG    = 2'd1,
    TGT_SIZE1 = 2'd2,
    TGT_SIZE10 = 2'd3
  } knob_tgt_e;

  // modifier chord -> register receiving the knob step
  function automatic knob_tgt_e route_knob(input logic south, input logic west);
    if (south && west) return TGT_SIZE10;
    if (south)         return TGT_SIZE1;
    if (west)          return TGT_BG;
    return TGT_FG;
  endfunction
endpackage

// File: rtl/slow_tick_div.sv
module slow_tick_div #(
  parameter int unsigned PERIOD = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (PERIOD > 1) begin : g_gap_chk
      a_r2_tick_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/btn_tick_sampler.sv
module btn_tick_sampler #(
  parameter int unsigned N_BTN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [N_BTN-1:0] raw_i,
  output logic [N_BTN-1:0] cur_o,
  output logic [N_BTN-1:0] rise_o
);
  logic [N_BTN-1:0] smp_q;

  for (genvar i = 0; i < N_BTN; i++) begin : g_btn
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     smp_q[i] <= 1'b0;
      else if (tick_i) smp_q[i] <= raw_i[i];
    end
    assign cur_o[i]  = tick_i ? raw_i[i] : smp_q[i];
    assign rise_o[i] = tick_i & raw_i[i] & ~smp_q[i];
  end

  a_r3_rise_only_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_o) |-> tick_i);
  a_r3_no_repeat_while_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (|rise_o)) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/wrap_counter.sv
module wrap_counter #(
  parameter int unsigned      W    = 3,
  parameter logic [W-1:0]     INIT = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= INIT;
    else if (inc_i) q_o <= q_o + 1'b1;
    else if (dec_i) q_o <= q_o - 1'b1;
  end

  a_r9_wrap_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && q_o == '1) |=> q_o == '0);
  a_r9_wrap_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && q_o == '0) |=> q_o == '1);
  a_r11_single_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_i && dec_i));
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] INIT = W'(16),
  parameter int unsigned  BIG  = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic         big_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] MAXV  = '1;
  localparam logic [W-1:0] BIG_V = W'(BIG);

  logic [W-1:0] step;
  logic [W:0]   sum;
  logic [W-1:0] nxt;

  assign step = big_i ? BIG_V : W'(1);
  assign sum  = {1'b0, q_o} + {1'b0, step};

  always_comb begin
    nxt = q_o;
    if (inc_i)      nxt = sum[W] ? MAXV : sum[W-1:0];
    else if (dec_i) nxt = (q_o < step) ? '0 : q_o - step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= INIT;
    else         q_o <= nxt;
  end

  a_r8_ceiling_big: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && big_i && q_o > (MAXV - BIG_V)) |=> q_o == MAXV);
  a_r7_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && q_o == '0) |=> q_o == '0);
  a_r7_dec_never_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i) |=> q_o <= $past(q_o));
  a_r7_inc_never_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> q_o >= $past(q_o));
endmodule

// File: rtl/knob_settings_bank.sv
module knob_settings_bank
  import knob_settings_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 50000,
  parameter int unsigned CTR_W       = 3,
  parameter int unsigned SIZE_W      = 8,
  parameter int unsigned SIZE_BIG    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              btn_north_i,
  input  logic              btn_east_i,
  input  logic              btn_south_i,
  input  logic              btn_west_i,
  input  logic              knob_step_i,
  input  logic              knob_up_i,
  output logic [CTR_W-1:0]  speed_h_o,
  output logic [CTR_W-1:0]  speed_v_o,
  output logic [CTR_W-1:0]  color_fg_o,
  output logic [CTR_W-1:0]  color_bg_o,
  output logic [SIZE_W-1:0] size_o
);
  localparam int unsigned B_N = 3, B_E = 2, B_S = 1, B_W = 0;

  logic       tick;
  logic [3:0] btn_raw, btn_cur, btn_rise;

  slow_tick_div #(.PERIOD(TICK_CYCLES)) u_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  assign btn_raw = {btn_north_i, btn_east_i, btn_south_i, btn_west_i};

  btn_tick_sampler #(.N_BTN(4)) u_smp (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .raw_i (btn_raw), .cur_o(btn_cur), .rise_o(btn_rise)
  );

  // knob strobes between ticks collapse to one pending step
  logic pend_q, pend_up_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      pend_up_q <= 1'b0;
    end else if (tick) begin
      pend_q    <= 1'b0;
    end else if (knob_step_i) begin
      pend_q    <= 1'b1;
      pend_up_q <= knob_up_i;
    end
  end

  logic      fire, fire_up;
  knob_tgt_e tgt;
  assign fire    = tick & (knob_step_i | pend_q);
  assign fire_up = knob_step_i ? knob_up_i : pend_up_q;
  assign tgt     = route_knob(btn_cur[B_S], btn_cur[B_W]);

  logic fg_inc, fg_dec, bg_inc, bg_dec, sz_inc, sz_dec, sz_big;
  assign fg_inc = fire &  fire_up & (tgt == TGT_FG);
  assign fg_dec = fire & ~fire_up & (tgt == TGT_FG);
  assign bg_inc = fire &  fire_up & (tgt == TGT_BG);
  assign bg_dec = fire & ~fire_up & (tgt == TGT_BG);
  assign sz_big = (tgt == TGT_SIZE10);
  assign sz_inc = fire &  fire_up & (tgt == TGT_SIZE1 || sz_big);
  assign sz_dec = fire & ~fire_up & (tgt == TGT_SIZE1 || sz_big);

  wrap_counter #(.W(CTR_W), .INIT(CTR_W'(1))) u_spd_h (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(btn_rise[B_E]), .dec_i(1'b0), .q_o(speed_h_o)
  );
  wrap_counter #(.W(CTR_W), .INIT(CTR_W'(1))) u_spd_v (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(btn_rise[B_N]), .dec_i(1'b0), .q_o(speed_v_o)
  );
  wrap_counter #(.W(CTR_W), .INIT('1)) u_fg (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(fg_inc), .dec_i(fg_dec), .q_o(color_fg_o)
  );
  wrap_counter #(.W(CTR_W), .INIT('0)) u_bg (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(bg_inc), .dec_i(bg_dec), .q_o(color_bg_o)
  );
  sat_counter #(.W(SIZE_W), .INIT(SIZE_W'(16)), .BIG(SIZE_BIG)) u_size (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(sz_inc), .dec_i(sz_dec), .big_i(sz_big), .q_o(size_o)
  );

  a_r2_quiet_off_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable({speed_h_o, speed_v_o, color_fg_o, color_bg_o, size_o}));
  a_r11_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fg_inc | fg_dec, bg_inc | bg_dec, sz_inc | sz_dec}));
  a_r11_step_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fg_inc | fg_dec | bg_inc | bg_dec | sz_inc | sz_dec) |-> tick);
endmodule

// File: tb/sim_knob_settings_bank.sv
module sim_knob_settings_bank;
  localparam int TP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] btn = '0;   // [3]=N [2]=E [1]=S [0]=W
  logic step = 1'b0, up = 1'b0;
  logic [2:0] sh, sv, fg, bg;
  logic [7:0] sz;
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  knob_settings_bank #(.TICK_CYCLES(TP)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .btn_north_i(btn[3]), .btn_east_i(btn[2]), .btn_south_i(btn[1]), .btn_west_i(btn[0]),
    .knob_step_i(step), .knob_up_i(up),
    .speed_h_o(sh), .speed_v_o(sv), .color_fg_o(fg), .color_bg_o(bg), .size_o(sz)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(int n);
    repeat (n * TP) @(negedge clk);
  endtask

  task automatic press(int idx);
    @(negedge clk); btn[idx] = 1'b1; wait_ticks(2);
    btn[idx] = 1'b0; wait_ticks(2);
  endtask

  task automatic knob(bit dir);
    @(negedge clk); step = 1'b1; up = dir;
    @(negedge clk); step = 1'b0; wait_ticks(2);
  endtask

  task automatic hold_mods(bit s, bit w);
    @(negedge clk); btn[1] = s; btn[0] = w; wait_ticks(2);
  endtask

  task automatic t_reset;
    chk("R1 speed_h", sh, 1); chk("R1 speed_v", sv, 1);
    chk("R1 fg", fg, 7); chk("R1 bg", bg, 0); chk("R1 size", sz, 16);
  endtask

  task automatic t_north;
    @(negedge clk); btn[3] = 1'b1; wait_ticks(5);
    chk("R3 held counts once", sv, 2);
    chk("R3 h untouched", sh, 1);
    btn[3] = 1'b0; wait_ticks(2);
    press(3);
    chk("R3 second press", sv, 3);
  endtask

  task automatic t_east_wrap;
    for (int i = 0; i < 7; i++) press(2);
    chk("R4 R9 east wraps to 0", sh, 0);
    chk("R4 v untouched", sv, 3);
  endtask

  task automatic t_fg;
    knob(1); chk("R5 R9 fg 7 up wraps", fg, 0);
    knob(0); chk("R5 R9 fg 0 down wraps", fg, 7);
    knob(0); chk("R5 fg down", fg, 6);
    chk("R5 bg untouched", bg, 0);
  endtask

  task automatic t_bg;
    hold_mods(0, 1);
    knob(0); chk("R6 R9 bg down wraps", bg, 7);
    knob(1); knob(1); chk("R6 bg up", bg, 1);
    chk("R6 fg untouched", fg, 6);
    hold_mods(0, 0);
  endtask

  task automatic t_size;
    hold_mods(1, 0);
    knob(1); chk("R7 size +1", sz, 17);
    chk("R7 fg untouched", fg, 6);
    hold_mods(1, 1);
    knob(0); chk("R8 size -10", sz, 7);
    knob(0); chk("R8 size floor", sz, 0);
    hold_mods(1, 0);
    knob(0); chk("R7 size floor", sz, 0);
    hold_mods(1, 1);
    for (int i = 0; i < 25; i++) knob(1);
    chk("R8 size 250", sz, 250);
    knob(1); chk("R8 size ceiling", sz, 255);
    hold_mods(1, 0);
    knob(1); chk("R7 size ceiling", sz, 255);
    knob(0); chk("R7 size -1", sz, 254);
    chk("R8 bg untouched", bg, 1);
    hold_mods(0, 0);
  endtask

  // place pulse inside the window, away from the sampling cycle (cyc%TP == TP-1)
  task automatic align_mid;
    @(negedge clk);
    while (cyc % TP != 2) @(negedge clk);
  endtask

  task automatic t_glitch;
    align_mid; btn[3] = 1'b1;
    repeat (3) @(negedge clk); btn[3] = 1'b0;
    wait_ticks(2);
    chk("R10 north glitch ignored", sv, 3);
    align_mid; btn[1] = 1'b1; btn[0] = 1'b1;
    repeat (2) @(negedge clk); btn[1] = 1'b0; btn[0] = 1'b0;
    wait_ticks(2);
    knob(1);
    chk("R10 modifier glitch ignored fg", fg, 7);
    chk("R10 size unchanged", sz, 254);
  endtask

  task automatic t_collapse;
    align_mid; step = 1'b1; up = 1'b1;
    @(negedge clk); step = 1'b0;
    @(negedge clk); step = 1'b1; up = 1'b0;
    @(negedge clk); step = 1'b0;
    chk("R2 no change before tick", fg, 7);
    wait_ticks(2);
    chk("R11 collapsed to last dir", fg, 6);
    chk("R11 bg untouched", bg, 1);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_north;
    t_east_wrap;
    t_fg;
    t_bg;
    t_size;
    t_glitch;
    t_collapse;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule